// File: doc/BRIEF.md
# Width-aware store instruction executor

This block carries out the store-register and store-zero instructions of a small accumulator-style processor whose index and memory registers switch between 8 and 16 bits at run time. A start pulse presents an already decoded opcode together with its operand bytes, the X, Y and direct-page registers, the data bank register and the two width flags. On that pulse the block forms a 24-bit effective address and latches the bytes to be stored. It then writes one or two bytes, in sequence, through a valid/ready byte write port.

When the last byte has been accepted, the block raises a one-cycle done pulse and presents the number of machine cycles the instruction costs. That count depends on the addressing mode, on the width of the stored operand and on whether the low byte of the direct-page register is zero. An opcode outside the supported set writes nothing and raises a one-cycle error pulse instead of done.

Top module: `store_unit`

## Requirements
- R1: Supported opcodes are 0x8E, 0x86 and 0x96 (store X: absolute, direct, direct+Y). They also include 0x8C, 0x84 and 0x94 (store Y: absolute, direct, direct+X), and 0x9C, 0x64, 0x9E and 0x74 (store zero: absolute, direct, absolute+X, direct+X). Any other opcode causes `bad_op` to be high for exactly the cycle after start, with no write and no done.
- R2: Store X and store Y write one byte, the register's low byte, when `x_flag` is 1, and two bytes when it is 0.
- R3: Store zero writes data 0x00. It writes two bytes when `m_flag` is 0 and one byte when it is 1.
- R4: A two-byte store writes the low byte at the effective address first, then the high byte at the effective address plus one, incremented over all 24 bits.
- R5: The absolute address is {`dbank`, `operand`}. Absolute+X adds the index to that 24-bit value.
- R6: A direct address has bank 0x00. Its low 16 bits are `dp_reg` + `operand[7:0]`, plus the index in the indexed forms, wrapped to 16 bits. `operand[15:8]` and `dbank` are ignored.
- R7: When `x_flag` is 1, only the low byte of the index register enters address calculation.
- R8: Absolute forms report 4 cycles, plus 1 for a 16-bit operand.
- R9: Direct forms report 3 cycles, plus 1 for a 16-bit operand, plus 1 when `dp_reg[7:0]` is nonzero.
- R10: Direct indexed forms report 4 cycles, plus the same two penalties as R9.
- R11: The operand width follows `x_flag` for store X and store Y, and `m_flag` for store zero. The other flag has no effect.
- R12: A write held with `wr_ready` low keeps its address and data steady. `done` is high for exactly the one cycle after the last byte is accepted, and `cycles` is valid while `done` is high.
- R13: `start` is ignored while `busy` is high. An instruction in progress writes only what was latched at its own start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Execute the presented instruction (taken when idle) |
| opcode | input | 8 | Decoded opcode |
| operand | input | 16 | Operand bytes |
| x_reg | input | 16 | X index register |
| y_reg | input | 16 | Y index register |
| dp_reg | input | 16 | Direct-page register |
| dbank | input | 8 | Data bank register |
| m_flag | input | 1 | 1 = memory operands are 8 bits |
| x_flag | input | 1 | 1 = index registers are 8 bits |
| wr_valid | output | 1 | Byte write request |
| wr_addr | output | 24 | Byte write address |
| wr_data | output | 8 | Byte write data |
| wr_ready | input | 1 | Write accepted when high with wr_valid |
| done | output | 1 | One-cycle completion pulse |
| cycles | output | 4 | Instruction cycle count, valid with done |
| bad_op | output | 1 | One-cycle unsupported-opcode pulse |
| busy | output | 1 | Instruction in progress |

## Verification
The first write request appears in the cycle after the start edge, and `bad_op` rises in that same cycle. Each following byte request appears in the cycle after the previous one is accepted, and `done` with `cycles` appears in the cycle after the last acceptance. The bench drives inputs and samples outputs on the falling edge. At each falling edge it decides `wr_ready` and records a handshake, so a byte that was stalled is counted only in the cycle of its acceptance. The done pulse is checked to be gone one cycle later.

// File: rtl/store_unit_pkg.sv
package store_unit_pkg;

    localparam int ADDR_W = 24;
    localparam int BYTE_W = 8;
    localparam int WORD_W = 16;

    localparam logic [7:0] OP_SX_ABS  = 8'h8E;
    localparam logic [7:0] OP_SX_DIR  = 8'h86;
    localparam logic [7:0] OP_SX_DIRY = 8'h96;
    localparam logic [7:0] OP_SY_ABS  = 8'h8C;
    localparam logic [7:0] OP_SY_DIR  = 8'h84;
    localparam logic [7:0] OP_SY_DIRX = 8'h94;
    localparam logic [7:0] OP_SZ_ABS  = 8'h9C;
    localparam logic [7:0] OP_SZ_DIR  = 8'h64;
    localparam logic [7:0] OP_SZ_ABSX = 8'h9E;
    localparam logic [7:0] OP_SZ_DIRX = 8'h74;

    typedef enum logic [2:0] {
        AM_ABS,
        AM_ABSX,
        AM_DIR,
        AM_DIRX,
        AM_DIRY
    } amode_e;

    typedef enum logic [1:0] {
        SRC_X,
        SRC_Y,
        SRC_ZERO
    } src_e;

    typedef struct packed {
        logic   known;
        amode_e mode;
        src_e   src;
    } dec_t;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_LO,
        PH_HI,
        PH_FIN
    } phase_e;

endpackage

// File: rtl/store_unit_decode.sv
module store_unit_decode
    import store_unit_pkg::*;
(
    input  logic [7:0] opcode,
    output dec_t       dec
);

    always_comb begin
        dec = '{known: 1'b1, mode: AM_ABS, src: SRC_X};
        case (opcode)
            OP_SX_ABS:  dec = '{known: 1'b1, mode: AM_ABS,  src: SRC_X};
            OP_SX_DIR:  dec = '{known: 1'b1, mode: AM_DIR,  src: SRC_X};
            OP_SX_DIRY: dec = '{known: 1'b1, mode: AM_DIRY, src: SRC_X};
            OP_SY_ABS:  dec = '{known: 1'b1, mode: AM_ABS,  src: SRC_Y};
            OP_SY_DIR:  dec = '{known: 1'b1, mode: AM_DIR,  src: SRC_Y};
            OP_SY_DIRX: dec = '{known: 1'b1, mode: AM_DIRX, src: SRC_Y};
            OP_SZ_ABS:  dec = '{known: 1'b1, mode: AM_ABS,  src: SRC_ZERO};
            OP_SZ_DIR:  dec = '{known: 1'b1, mode: AM_DIR,  src: SRC_ZERO};
            OP_SZ_ABSX: dec = '{known: 1'b1, mode: AM_ABSX, src: SRC_ZERO};
            OP_SZ_DIRX: dec = '{known: 1'b1, mode: AM_DIRX, src: SRC_ZERO};
            default:    dec = '{known: 1'b0, mode: AM_ABS,  src: SRC_X};
        endcase
    end

endmodule

// File: rtl/store_unit_agen.sv
module store_unit_agen
    import store_unit_pkg::*;
(
    input  amode_e              mode,
    input  logic [WORD_W-1:0]   operand,
    input  logic [WORD_W-1:0]   x_reg,
    input  logic [WORD_W-1:0]   y_reg,
    input  logic [WORD_W-1:0]   dp_reg,
    input  logic [BYTE_W-1:0]   dbank,
    input  logic                x_flag,
    output logic [ADDR_W-1:0]   ea
);

    logic [WORD_W-1:0] idx_raw;
    logic [WORD_W-1:0] idx;
    logic [ADDR_W-1:0] abs_ea;
    logic [WORD_W-1:0] dir_ea;

    always_comb begin
        idx_raw = (mode == AM_DIRY) ? y_reg : x_reg;
        // 8-bit index width: upper half of the index does not take part
        idx     = x_flag ? {{(WORD_W-BYTE_W){1'b0}}, idx_raw[BYTE_W-1:0]} : idx_raw;
        abs_ea  = {dbank, operand};
        dir_ea  = dp_reg + {{(WORD_W-BYTE_W){1'b0}}, operand[BYTE_W-1:0]};
        case (mode)
            AM_ABS:  ea = abs_ea;
            AM_ABSX: ea = abs_ea + {{(ADDR_W-WORD_W){1'b0}}, idx};
            AM_DIR:  ea = {{(ADDR_W-WORD_W){1'b0}}, dir_ea};
            default: ea = {{(ADDR_W-WORD_W){1'b0}}, dir_ea + idx};
        endcase
    end

endmodule

// File: rtl/store_unit_cost.sv
module store_unit_cost
    import store_unit_pkg::*;
#(
    parameter int CYC_W = 4
) (
    input  amode_e           mode,
    input  logic             wide,
    input  logic             dl_nz,
    output logic [CYC_W-1:0] cyc
);

    logic [CYC_W-1:0] base;
    logic             dir_form;

    always_comb begin
        dir_form = (mode == AM_DIR) || (mode == AM_DIRX) || (mode == AM_DIRY);
        base     = (mode == AM_DIR) ? CYC_W'(3) : CYC_W'(4);
        cyc      = base + CYC_W'(wide) + CYC_W'(dir_form & dl_nz);
    end

endmodule

// File: rtl/store_unit.sv
module store_unit
    import store_unit_pkg::*;
#(
    parameter int CYC_W = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [7:0]         opcode,
    input  logic [15:0]        operand,
    input  logic [15:0]        x_reg,
    input  logic [15:0]        y_reg,
    input  logic [15:0]        dp_reg,
    input  logic [7:0]         dbank,
    input  logic               m_flag,
    input  logic               x_flag,
    output logic               wr_valid,
    output logic [23:0]        wr_addr,
    output logic [7:0]         wr_data,
    input  logic               wr_ready,
    output logic               done,
    output logic [CYC_W-1:0]   cycles,
    output logic               bad_op,
    output logic               busy
);

    typedef struct packed {
        phase_e              phase;
        logic [ADDR_W-1:0]   addr;
        logic [BYTE_W-1:0]   lo;
        logic [BYTE_W-1:0]   hi;
        logic                wide;
        logic [CYC_W-1:0]    cyc;
        logic                bad;
    } st_t;

    localparam st_t ST_RESET = '{
        phase: PH_IDLE, addr: '0, lo: '0, hi: '0, wide: 1'b0, cyc: '0, bad: 1'b0
    };

    dec_t              dec;
    logic [ADDR_W-1:0] ea;
    logic [CYC_W-1:0]  cost;
    logic              wide_now;
    logic [WORD_W-1:0] src_val;
    st_t               s_d;
    st_t               s_q;

    store_unit_decode u_dec (
        .opcode (opcode),
        .dec    (dec)
    );

    store_unit_agen u_agen (
        .mode    (dec.mode),
        .operand (operand),
        .x_reg   (x_reg),
        .y_reg   (y_reg),
        .dp_reg  (dp_reg),
        .dbank   (dbank),
        .x_flag  (x_flag),
        .ea      (ea)
    );

    always_comb begin
        wide_now = (dec.src == SRC_ZERO) ? ~m_flag : ~x_flag;
        case (dec.src)
            SRC_X:   src_val = x_reg;
            SRC_Y:   src_val = y_reg;
            default: src_val = '0;
        endcase
    end

    store_unit_cost #(.CYC_W(CYC_W)) u_cost (
        .mode  (dec.mode),
        .wide  (wide_now),
        .dl_nz (|dp_reg[BYTE_W-1:0]),
        .cyc   (cost)
    );

    always_comb begin
        s_d     = s_q;
        s_d.bad = 1'b0;
        case (s_q.phase)
            PH_IDLE: begin
                if (start) begin
                    if (dec.known) begin
                        s_d.phase = PH_LO;
                        s_d.addr  = ea;
                        s_d.lo    = src_val[BYTE_W-1:0];
                        s_d.hi    = src_val[WORD_W-1:BYTE_W];
                        s_d.wide  = wide_now;
                        s_d.cyc   = cost;
                    end else begin
                        s_d.bad   = 1'b1;
                    end
                end
            end
            PH_LO: begin
                if (wr_ready) begin
                    s_d.phase = s_q.wide ? PH_HI : PH_FIN;
                end
            end
            PH_HI: begin
                if (wr_ready) begin
                    s_d.phase = PH_FIN;
                end
            end
            default: s_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= ST_RESET;
        end else begin
            s_q <= s_d;
        end
    end

    always_comb begin
        wr_valid = (s_q.phase == PH_LO) || (s_q.phase == PH_HI);
        wr_addr  = (s_q.phase == PH_HI) ? s_q.addr + {{(ADDR_W-1){1'b0}}, 1'b1} : s_q.addr;
        wr_data  = (s_q.phase == PH_HI) ? s_q.hi : s_q.lo;
        done     = (s_q.phase == PH_FIN);
        cycles   = s_q.cyc;
        bad_op   = s_q.bad;
        busy     = (s_q.phase != PH_IDLE);
    end

endmodule

// File: rtl/store_unit_chk.sv
module store_unit_chk #(
    parameter int CYC_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_valid,
    input logic             wr_ready,
    input logic [23:0]      wr_addr,
    input logic [7:0]       wr_data,
    input logic             done,
    input logic [CYC_W-1:0] cycles,
    input logic             bad_op
);

    assert_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_addr) && $stable(wr_data)));

    assert_done_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_done_after_accept_R12: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(wr_valid && wr_ready));

    assert_bad_no_write_R1: assert property (@(posedge clk) disable iff (!rst_n)
        bad_op |-> (!wr_valid && !done));

    assert_bad_pulse_R1: assert property (@(posedge clk) disable iff (!rst_n)
        bad_op |=> !bad_op);

    assert_second_addr_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(wr_valid && wr_ready) && wr_valid) |-> (wr_addr == $past(wr_addr) + 24'd1));

    assert_cycles_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (cycles >= CYC_W'(3) && cycles <= CYC_W'(6)));

endmodule

bind store_unit store_unit_chk #(.CYC_W(CYC_W)) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_valid (wr_valid),
    .wr_ready (wr_ready),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .done     (done),
    .cycles   (cycles),
    .bad_op   (bad_op)
);

// File: tb/store_unit_tb.sv
module store_unit_tb_top;

    typedef struct packed {
        logic [7:0]  op;
        logic [15:0] opnd;
        logic [15:0] xr;
        logic [15:0] yr;
        logic [15:0] dpr;
        logic [7:0]  db;
        logic        mf;
        logic        xf;
        logic [1:0]  stall;
        logic [1:0]  n;
        logic [23:0] a0;
        logic [7:0]  d0;
        logic [7:0]  d1;
        logic [3:0]  cyc;
        logic        bad;
    } vec_t;

    localparam int NV = 16;
    localparam vec_t VECS [NV] = '{
        '{8'h8E, 16'h1234, 16'h11AB, 16'h0000, 16'h0000, 8'h7E, 1'b1, 1'b0, 2'd0, 2'd2, 24'h7E1234, 8'hAB, 8'h11, 4'd5, 1'b0},
        '{8'h8E, 16'h1234, 16'h11AB, 16'h0000, 16'h0000, 8'h7E, 1'b0, 1'b1, 2'd1, 2'd1, 24'h7E1234, 8'hAB, 8'h00, 4'd4, 1'b0},
        '{8'h86, 16'hAA40, 16'h0055, 16'h0000, 16'h0000, 8'h00, 1'b1, 1'b1, 2'd0, 2'd1, 24'h000040, 8'h55, 8'h00, 4'd3, 1'b0},
        '{8'h96, 16'h0010, 16'hBEEF, 16'h0205, 16'h0100, 8'h33, 1'b1, 1'b0, 2'd2, 2'd2, 24'h000315, 8'hEF, 8'hBE, 4'd5, 1'b0},
        '{8'h8C, 16'hABCD, 16'h0000, 16'h3344, 16'h0000, 8'h01, 1'b1, 1'b0, 2'd0, 2'd2, 24'h01ABCD, 8'h44, 8'h33, 4'd5, 1'b0},
        '{8'h84, 16'h0020, 16'h0000, 16'h0077, 16'h1203, 8'h00, 1'b1, 1'b1, 2'd3, 2'd1, 24'h001223, 8'h77, 8'h00, 4'd4, 1'b0},
        '{8'h94, 16'h00F0, 16'h1234, 16'h0099, 16'hFF80, 8'h00, 1'b1, 1'b1, 2'd0, 2'd1, 24'h0000A4, 8'h99, 8'h00, 4'd5, 1'b0},
        '{8'h9C, 16'h2000, 16'hFFFF, 16'hFFFF, 16'h0000, 8'h7F, 1'b0, 1'b1, 2'd1, 2'd2, 24'h7F2000, 8'h00, 8'h00, 4'd5, 1'b0},
        '{8'h64, 16'h0005, 16'h0000, 16'h0000, 16'h0300, 8'h00, 1'b1, 1'b0, 2'd0, 2'd1, 24'h000305, 8'h00, 8'h00, 4'd3, 1'b0},
        '{8'h9E, 16'hFFFF, 16'h0002, 16'h0000, 16'h0000, 8'h12, 1'b1, 1'b0, 2'd0, 2'd1, 24'h130001, 8'h00, 8'h00, 4'd4, 1'b0},
        '{8'h74, 16'h0010, 16'h0100, 16'h0000, 16'h0001, 8'h00, 1'b0, 1'b0, 2'd2, 2'd2, 24'h000111, 8'h00, 8'h00, 4'd6, 1'b0},
        '{8'h8C, 16'h0000, 16'h0000, 16'hCAFE, 16'h0000, 8'h00, 1'b0, 1'b1, 2'd0, 2'd1, 24'h000000, 8'hFE, 8'h00, 4'd4, 1'b0},
        '{8'h8E, 16'hFFFF, 16'h0102, 16'h0000, 16'h0000, 8'h7E, 1'b1, 1'b0, 2'd1, 2'd2, 24'h7EFFFF, 8'h02, 8'h01, 4'd5, 1'b0},
        '{8'h94, 16'h0001, 16'h0180, 16'h1234, 16'h0010, 8'h00, 1'b1, 1'b1, 2'd0, 2'd1, 24'h000091, 8'h34, 8'h00, 4'd5, 1'b0},
        '{8'h8D, 16'h1234, 16'h5555, 16'h5555, 16'h0000, 8'h7E, 1'b0, 1'b0, 2'd0, 2'd0, 24'h000000, 8'h00, 8'h00, 4'd0, 1'b1},
        '{8'h00, 16'h0000, 16'h5555, 16'h5555, 16'h0000, 8'h00, 1'b1, 1'b1, 2'd0, 2'd0, 24'h000000, 8'h00, 8'h00, 4'd0, 1'b1}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [7:0]  opcode = '0;
    logic [15:0] operand = '0;
    logic [15:0] x_reg = '0;
    logic [15:0] y_reg = '0;
    logic [15:0] dp_reg = '0;
    logic [7:0]  dbank = '0;
    logic        m_flag = 1'b1;
    logic        x_flag = 1'b1;
    logic        wr_ready = 1'b0;
    logic        wr_valid;
    logic [23:0] wr_addr;
    logic [7:0]  wr_data;
    logic        done;
    logic [3:0]  cycles;
    logic        bad_op;
    logic        busy;

    int          n_tests = 0;
    int          n_fail = 0;
    bit          finished = 1'b0;

    int          got_n;
    logic [23:0] got_a [2];
    logic [7:0]  got_d [2];
    logic [3:0]  got_cyc;
    bit          got_done;
    bit          got_bad;

    always #10 clk = ~clk;

    store_unit dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .opcode   (opcode),
        .operand  (operand),
        .x_reg    (x_reg),
        .y_reg    (y_reg),
        .dp_reg   (dp_reg),
        .dbank    (dbank),
        .m_flag   (m_flag),
        .x_flag   (x_flag),
        .wr_valid (wr_valid),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .wr_ready (wr_ready),
        .done     (done),
        .cycles   (cycles),
        .bad_op   (bad_op),
        .busy     (busy)
    );

    task automatic check(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", what, act, exp);
        end
    endtask

    // Drives one instruction and logs the handshakes; keep_start holds start high and
    // disturbs the inputs while the instruction is in progress.
    task automatic run(input vec_t v, input bit keep_start);
        int waited;
        bit stop;
        @(negedge clk);
        opcode = v.op; operand = v.opnd; x_reg = v.xr; y_reg = v.yr;
        dp_reg = v.dpr; dbank = v.db; m_flag = v.mf; x_flag = v.xf;
        start = 1'b1; wr_ready = 1'b0;
        got_n = 0; got_done = 1'b0; got_bad = 1'b0; got_cyc = '0;
        got_a[0] = '0; got_a[1] = '0; got_d[0] = '0; got_d[1] = '0;
        waited = 0; stop = 1'b0;
        @(posedge clk);
        for (int t = 0; t < 30 && !stop; t++) begin
            @(negedge clk);
            if (keep_start) begin
                opcode = 8'h64; x_reg = 16'h0000; y_reg = 16'h0000; operand = 16'h0F0F;
            end else begin
                start = 1'b0;
            end
            wr_ready = (waited >= int'(v.stall));
            if (wr_valid && !wr_ready) waited++;
            if (wr_valid && wr_ready) begin
                if (got_n < 2) begin
                    got_a[got_n] = wr_addr;
                    got_d[got_n] = wr_data;
                end
                got_n++;
                waited = 0;
            end
            if (bad_op) got_bad = 1'b1;
            if (done) begin
                got_done = 1'b1;
                got_cyc = cycles;
                start = 1'b0;
                stop = 1'b1;
            end
            if (got_bad && t > 5) stop = 1'b1;
            if (!stop) @(posedge clk);
        end
        start = 1'b0;
        wr_ready = 1'b0;
    endtask

    task automatic judge(input vec_t v, input int idx);
        string tg;
        tg = $sformatf("vec%0d", idx);
        check(got_bad == v.bad, {tg, " R1 bad_op"}, 32'(got_bad), 32'(v.bad));
        check(got_n == int'(v.n), {tg, " R2/R3/R11 byte count"}, 32'(got_n), 32'(v.n));
        if (!v.bad) begin
            check(got_done, {tg, " R12 done seen"}, 32'(got_done), 32'd1);
            check(got_a[0] == v.a0, {tg, " R5/R6/R7 address"}, 32'(got_a[0]), 32'(v.a0));
            check(got_d[0] == v.d0, {tg, " R2/R3 low data"}, 32'(got_d[0]), 32'(v.d0));
            check(got_cyc == v.cyc, {tg, " R8/R9/R10/R11 cycles"}, 32'(got_cyc), 32'(v.cyc));
            if (v.n == 2'd2) begin
                check(got_a[1] == v.a0 + 24'd1, {tg, " R4 second address"}, 32'(got_a[1]), 32'(v.a0 + 24'd1));
                check(got_d[1] == v.d1, {tg, " R4 high data"}, 32'(got_d[1]), 32'(v.d1));
            end
        end else begin
            check(!got_done, {tg, " R1 no done"}, 32'(got_done), 32'd0);
        end
    endtask

    initial begin
        vec_t sv;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(!wr_valid && !done && !bad_op && !busy, "reset outputs idle (R12)",
              {28'd0, wr_valid, done, bad_op, busy}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!wr_valid && !busy, "after reset idle (R13)", {30'd0, wr_valid, busy}, 32'd0);

        for (int i = 0; i < NV; i++) begin
            run(VECS[i], 1'b0);
            judge(VECS[i], i);
        end

        // done is a single-cycle pulse (R12)
        run(VECS[0], 1'b0);
        @(negedge clk);
        check(!done, "R12 done gone next cycle", 32'(done), 32'd0);
        check(!busy, "R12 idle after done", 32'(busy), 32'd0);

        // start held high with changed inputs while busy is ignored (R13)
        sv = '{8'h8E, 16'h4000, 16'h5566, 16'h0000, 16'h0000, 8'h00, 1'b1, 1'b0, 2'd2, 2'd2,
               24'h004000, 8'h66, 8'h55, 4'd5, 1'b0};
        run(sv, 1'b1);
        check(got_n == 2, "R13 byte count while restarted", 32'(got_n), 32'd2);
        check(got_d[0] == 8'h66 && got_d[1] == 8'h55, "R13 latched data",
              {16'd0, got_d[1], got_d[0]}, 32'h5566);
        check(got_a[0] == 24'h004000, "R13 latched address", 32'(got_a[0]), 32'h004000);
        check(got_cyc == 4'd5, "R13 latched cycles", 32'(got_cyc), 32'd5);
        repeat (3) @(negedge clk);
        check(!wr_valid && !busy, "R13 no extra instruction", {30'd0, wr_valid, busy}, 32'd0);

        if (!finished) begin
            finished = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_tests++;
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule